// File: doc/BRIEF.md
# Instruction Prefetch Queue Controller

This block keeps a small first-in first-out store of instruction bytes ahead of the execution side. It also decides who owns a single word-wide memory bus in each bus cycle. When the store has room for at least two more bytes and nothing else wants the bus, it fetches the next code word from the physical address formed from the code segment and the fetch pointer. The execution side removes one byte per accepted request. Operand reads and writes from the execution side take priority over new code fetches, but they never cut short a code fetch that has already started.

A branch input empties the store in one cycle and loads a new fetch pointer. A fetch still in flight when the branch arrives runs to completion on the bus, and its data is thrown away. A branch to an odd target first fetches a single byte, so that every later fetch is word-aligned. Once the store cannot take another word and no operand is waiting, the bus stays idle.

Top module: `pfq_ctrl`

## Requirements
- R1: The queue never holds more than DEPTH (default 6) bytes. Starting from empty at an even pointer with no reads and no operand traffic, exactly DEPTH/2 code fetches are made and then fetching stops.
- R2: A code fetch starts only from an idle bus, only when the queue level is at most DEPTH-2, and only when `opr_req_i` is low. If an operand request and a possible fetch are both present on an idle bus, the operand cycle goes first.
- R3: A word fetch puts an even address on `bus_addr_o` with `bus_byte_o` = 0. It queues bits 7:0 of `bus_rdata_i` first and bits 15:8 second, so bytes leave the queue in ascending address order.
- R4: Each cycle with `rd_req_i` high and `rd_valid_o` high removes exactly one byte, and `rd_data_o` shows the oldest byte. `rd_valid_o` is low when the queue is empty or after reset, and `rd_req_i` has no effect then.
- R5: Once a bus cycle starts, `bus_req_o`, `bus_code_o` and `bus_addr_o` hold until `bus_done_i`. An operand request raised during a code fetch is served only after that fetch completes.
- R6: A cycle with `branch_i` high empties the queue, so `rd_valid_o` is low in the next cycle. Later fetches start at the new target.
- R7: The code fetch address is `cs_i`*16 + pointer, modulo 2^20.
- R8: After an accepted word fetch the fetch pointer advances by 2. After a single-byte fetch it advances by 1. The pointer wraps at 16 bits.
- R9: When the pointer is odd, the fetch drives `bus_byte_o` = 1 at the odd address and queues only bits 15:8 of `bus_rdata_i`.
- R10: Data returned by a code fetch that was in flight at a branch, or that completes in the branch cycle itself, is never queued.
- R11: While the queue level is above DEPTH-2 and no operand request is present, `bus_req_o` stays low.
- R12: An operand cycle drives `opr_addr_i`, `opr_we_i` and `opr_wdata_i` onto the bus with `bus_code_o` = 0. It pulses `opr_done_o` together with `bus_done_i` and returns `bus_rdata_i` on `opr_rdata_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 16 | Code segment used for fetch addresses |
| branch_i | input | 1 | Taken-branch flush; loads `br_ip_i` as the fetch pointer |
| br_ip_i | input | 16 | Branch target offset |
| rd_req_i | input | 1 | Execution side takes one byte |
| rd_data_o | output | 8 | Oldest queued byte |
| rd_valid_o | output | 1 | Queue not empty |
| opr_req_i | input | 1 | Operand access request, held until done |
| opr_we_i | input | 1 | Operand access is a write |
| opr_addr_i | input | 20 | Operand physical address |
| opr_wdata_i | input | 16 | Operand write data |
| opr_done_o | output | 1 | Operand access finished |
| opr_rdata_o | output | 16 | Operand read data |
| bus_req_o | output | 1 | Bus cycle active |
| bus_code_o | output | 1 | Active cycle is a code fetch |
| bus_byte_o | output | 1 | Code fetch of a single (upper) byte |
| bus_we_o | output | 1 | Active cycle writes |
| bus_addr_o | output | 20 | Bus physical address |
| bus_wdata_o | output | 16 | Bus write data |
| bus_done_i | input | 1 | Bus sequencer finished the current cycle |
| bus_rdata_i | input | 16 | Bus read data |

## Verification
The assertions assume the bus sequencer raises `bus_done_i` only while `bus_req_o` is high, for a single cycle. They also assume the operand requester keeps `opr_req_i`, `opr_addr_i`, `opr_we_i` and `opr_wdata_i` unchanged from request until `opr_done_o`. The stimulus meets both conditions: a responder model in the bench completes each bus cycle after a programmable latency and drops `bus_done_i` on the next cycle. Operand tasks hold all request fields until the done pulse and release them before the following edge. Branches are issued both while the bus is idle and while a slow fetch is in flight, and never in a way that changes the operand fields mid-cycle.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
   localparam int SEG_W   = 16;
   localparam int OFF_W   = 16;
   localparam int PADDR_W = 20;
   localparam int WORD_W  = 16;
   localparam int BYTE_W  = 8;

   typedef enum logic [1:0] {
      BUS_IDLE = 2'd0,
      BUS_CODE = 2'd1,
      BUS_OPER = 2'd2
   } bus_st_e;

   // segment shifted by four plus the offset, wrapping at the address width
   function automatic logic [PADDR_W-1:0] phys_addr(input logic [SEG_W-1:0] seg,
                                                    input logic [OFF_W-1:0] off);
      return {seg, 4'h0} + PADDR_W'(off);
   endfunction
endpackage

// File: rtl/pfq_fifo.sv
module pfq_fifo #(
   parameter int DEPTH = 6,
   parameter int BW    = 8,
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          wr_en,
   input  logic          wr_two,
   input  logic [BW-1:0] wr_lo,
   input  logic [BW-1:0] wr_hi,
   input  logic          rd_en,
   output logic [BW-1:0] rd_data,
   output logic [LW-1:0] level
);
   logic [BW-1:0] mem [DEPTH];
   logic [PW-1:0] wp, rp, wp1, wp2, rp1;
   logic [1:0]    wcnt;

   // pointer stepping: free wrap for power-of-two depth, compare otherwise
   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wp1 = wp + 1'b1;
         assign wp2 = wp1 + 1'b1;
         assign rp1 = rp + 1'b1;
      end else begin : g_wrap
         assign wp1 = (wp  == PW'(DEPTH - 1)) ? '0 : wp  + 1'b1;
         assign wp2 = (wp1 == PW'(DEPTH - 1)) ? '0 : wp1 + 1'b1;
         assign rp1 = (rp  == PW'(DEPTH - 1)) ? '0 : rp  + 1'b1;
      end
   endgenerate

   assign wcnt    = wr_en ? (wr_two ? 2'd2 : 2'd1) : 2'd0;
   assign rd_data = mem[rp];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else if (clear) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else begin
         if (wr_en) wp <= wr_two ? wp2 : wp1;
         if (rd_en) rp <= rp1;
         level <= level + LW'(wcnt) - LW'(rd_en);
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en && !clear) begin
         mem[wp] <= wr_lo;
         if (wr_two) mem[wp1] <= wr_hi;
      end
   end
endmodule

// File: rtl/pfq_fetch_seq.sv
module pfq_fetch_seq
   import pfq_pkg::*;
#(
   parameter int                DEPTH    = 6,
   parameter logic [OFF_W-1:0]  RESET_IP = '0,
   localparam int               LW       = $clog2(DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SEG_W-1:0]   cs_i,
   input  logic               branch_i,
   input  logic [OFF_W-1:0]   br_ip_i,
   input  logic               opr_req_i,
   input  logic [LW-1:0]      level_i,
   input  logic               bus_done_i,
   input  logic [WORD_W-1:0]  bus_rdata_i,
   output bus_st_e            st_o,
   output logic [PADDR_W-1:0] fetch_addr_o,
   output logic               fetch_byte_o,
   output logic               q_wr_en_o,
   output logic               q_wr_two_o,
   output logic [BYTE_W-1:0]  q_wr_lo_o,
   output logic [BYTE_W-1:0]  q_wr_hi_o
);
   bus_st_e            st;
   logic [OFF_W-1:0]   ip_q;
   logic [PADDR_W-1:0] fa_q;
   logic               odd_q;
   logic               drop_q;
   logic               room;
   logic               accept;

   assign room   = level_i <= LW'(DEPTH - 2);
   assign accept = (st == BUS_CODE) && bus_done_i && !drop_q && !branch_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= BUS_IDLE;
         ip_q   <= RESET_IP;
         fa_q   <= '0;
         odd_q  <= 1'b0;
         drop_q <= 1'b0;
      end else begin
         case (st)
            BUS_IDLE: begin
               if (opr_req_i) begin
                  st <= BUS_OPER;
               end else if (!branch_i && room) begin
                  st    <= BUS_CODE;
                  fa_q  <= phys_addr(cs_i, ip_q);
                  odd_q <= ip_q[0];
               end
            end
            BUS_CODE: if (bus_done_i) st <= BUS_IDLE;
            BUS_OPER: if (bus_done_i) st <= BUS_IDLE;
            default:  st <= BUS_IDLE;
         endcase

         if (st == BUS_CODE) begin
            if (bus_done_i)    drop_q <= 1'b0;
            else if (branch_i) drop_q <= 1'b1;
         end

         if (branch_i)    ip_q <= br_ip_i;
         else if (accept) ip_q <= ip_q + (odd_q ? OFF_W'(1) : OFF_W'(2));
      end
   end

   assign st_o         = st;
   assign fetch_addr_o = fa_q;
   assign fetch_byte_o = odd_q;
   assign q_wr_en_o    = accept;
   assign q_wr_two_o   = !odd_q;
   assign q_wr_lo_o    = odd_q ? bus_rdata_i[15:8] : bus_rdata_i[7:0];
   assign q_wr_hi_o    = bus_rdata_i[15:8];
endmodule

// File: rtl/pfq_ctrl.sv
module pfq_ctrl
   import pfq_pkg::*;
#(
   parameter int               DEPTH    = 6,
   parameter logic [OFF_W-1:0] RESET_IP = '0,
   localparam int              LW       = $clog2(DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SEG_W-1:0]   cs_i,
   input  logic               branch_i,
   input  logic [OFF_W-1:0]   br_ip_i,
   input  logic               rd_req_i,
   output logic [BYTE_W-1:0]  rd_data_o,
   output logic               rd_valid_o,
   input  logic               opr_req_i,
   input  logic               opr_we_i,
   input  logic [PADDR_W-1:0] opr_addr_i,
   input  logic [WORD_W-1:0]  opr_wdata_i,
   output logic               opr_done_o,
   output logic [WORD_W-1:0]  opr_rdata_o,
   output logic               bus_req_o,
   output logic               bus_code_o,
   output logic               bus_byte_o,
   output logic               bus_we_o,
   output logic [PADDR_W-1:0] bus_addr_o,
   output logic [WORD_W-1:0]  bus_wdata_o,
   input  logic               bus_done_i,
   input  logic [WORD_W-1:0]  bus_rdata_i
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("pfq_ctrl: DEPTH must hold at least one fetched word");
      end
      if (WORD_W != 2 * BYTE_W) begin : g_bad_word
         $error("pfq_ctrl: bus word must be two bytes");
      end
   endgenerate

   bus_st_e            st;
   logic [PADDR_W-1:0] fetch_addr;
   logic               fetch_byte;
   logic               q_wr_en, q_wr_two, q_rd_en;
   logic [BYTE_W-1:0]  q_wr_lo, q_wr_hi;
   logic [LW-1:0]      q_level;

   assign q_rd_en = rd_req_i && (q_level != '0) && !branch_i;

   pfq_fetch_seq #(.DEPTH(DEPTH), .RESET_IP(RESET_IP)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .cs_i         (cs_i),
      .branch_i     (branch_i),
      .br_ip_i      (br_ip_i),
      .opr_req_i    (opr_req_i),
      .level_i      (q_level),
      .bus_done_i   (bus_done_i),
      .bus_rdata_i  (bus_rdata_i),
      .st_o         (st),
      .fetch_addr_o (fetch_addr),
      .fetch_byte_o (fetch_byte),
      .q_wr_en_o    (q_wr_en),
      .q_wr_two_o   (q_wr_two),
      .q_wr_lo_o    (q_wr_lo),
      .q_wr_hi_o    (q_wr_hi)
   );

   pfq_fifo #(.DEPTH(DEPTH), .BW(BYTE_W)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (branch_i),
      .wr_en   (q_wr_en),
      .wr_two  (q_wr_two),
      .wr_lo   (q_wr_lo),
      .wr_hi   (q_wr_hi),
      .rd_en   (q_rd_en),
      .rd_data (rd_data_o),
      .level   (q_level)
   );

   assign rd_valid_o  = q_level != '0;
   assign bus_req_o   = st != BUS_IDLE;
   assign bus_code_o  = st == BUS_CODE;
   assign bus_byte_o  = (st == BUS_CODE) && fetch_byte;
   assign bus_we_o    = (st == BUS_OPER) && opr_we_i;
   assign bus_addr_o  = (st == BUS_CODE) ? fetch_addr : opr_addr_i;
   assign bus_wdata_o = opr_wdata_i;
   assign opr_done_o  = (st == BUS_OPER) && bus_done_i;
   assign opr_rdata_o = bus_rdata_i;
endmodule

// File: rtl/pfq_ctrl_chk.sv
module pfq_ctrl_chk #(
   parameter int  DEPTH = 6,
   localparam int LW    = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic [LW-1:0] level,
   input logic          bus_req_o,
   input logic          bus_code_o,
   input logic          bus_byte_o,
   input logic [19:0]   bus_addr_o,
   input logic          bus_done_i,
   input logic          opr_req_i,
   input logic          branch_i,
   input logic          rd_valid_o
);
   assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LW'(DEPTH));

   assert_fetch_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && bus_code_o && !$past(bus_req_o))
         |-> ($past(level) <= LW'(DEPTH - 2) && !$past(opr_req_i)));

   assert_cycle_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && !bus_done_i)
         |=> (bus_req_o && $stable(bus_code_o) && $stable(bus_addr_o)));

   assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
      branch_i |=> !rd_valid_o);

   assert_odd_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && bus_byte_o) |-> (bus_code_o && bus_addr_o[0]));

   assert_idle_when_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_req_o && level > LW'(DEPTH - 2) && !opr_req_i) |=> !bus_req_o);
endmodule

bind pfq_ctrl pfq_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .level      (q_level),
   .bus_req_o  (bus_req_o),
   .bus_code_o (bus_code_o),
   .bus_byte_o (bus_byte_o),
   .bus_addr_o (bus_addr_o),
   .bus_done_i (bus_done_i),
   .opr_req_i  (opr_req_i),
   .branch_i   (branch_i),
   .rd_valid_o (rd_valid_o)
);

// File: tb/pfq_ctrl_test.sv
module pfq_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] cs_i;
   logic        branch_i;
   logic [15:0] br_ip_i;
   logic        rd_req_i;
   logic [7:0]  rd_data_o;
   logic        rd_valid_o;
   logic        opr_req_i, opr_we_i;
   logic [19:0] opr_addr_i;
   logic [15:0] opr_wdata_i;
   logic        opr_done_o;
   logic [15:0] opr_rdata_o;
   logic        bus_req_o, bus_code_o, bus_byte_o, bus_we_o;
   logic [19:0] bus_addr_o;
   logic [15:0] bus_wdata_o;
   logic        bus_done_i;
   logic [15:0] bus_rdata_i;

   int n_chk = 0;
   int n_fail = 0;
   int lat = 1;
   int n_tx = 0;
   int n0;
   logic [7:0]  d;
   logic [15:0] got_rd;

   logic        lg_code [256];
   logic        lg_byte [256];
   logic        lg_we   [256];
   logic [19:0] lg_addr [256];
   logic [15:0] lg_wd   [256];

   // 100 MHz
   always #5 clk = ~clk;

   pfq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .branch_i(branch_i), .br_ip_i(br_ip_i),
      .rd_req_i(rd_req_i), .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o),
      .opr_req_i(opr_req_i), .opr_we_i(opr_we_i), .opr_addr_i(opr_addr_i),
      .opr_wdata_i(opr_wdata_i), .opr_done_o(opr_done_o), .opr_rdata_o(opr_rdata_o),
      .bus_req_o(bus_req_o), .bus_code_o(bus_code_o), .bus_byte_o(bus_byte_o),
      .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o),
      .bus_done_i(bus_done_i), .bus_rdata_i(bus_rdata_i)
   );

   function automatic logic [7:0] cb(input logic [19:0] a);
      return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'h3C;
   endfunction

   function automatic logic [15:0] code_word(input logic [19:0] a);
      logic [19:0] e;
      e = {a[19:1], 1'b0};
      return {cb(e + 20'd1), cb(e)};
   endfunction

   function automatic logic [15:0] opr_resp(input logic [19:0] a);
      return a[15:0] ^ 16'hA5A5;
   endfunction

   function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
      return {s, 4'h0} + {4'h0, o};
   endfunction

   task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
      end
   endtask

   // bus sequencer model: completes each cycle after lat cycles
   initial begin
      int cnt;
      cnt = 0;
      bus_done_i  = 1'b0;
      bus_rdata_i = '0;
      forever begin
         @(posedge clk);
         #2;
         if (bus_done_i) begin
            bus_done_i = 1'b0;
            cnt = 0;
         end else if (bus_req_o) begin
            cnt++;
            if (cnt >= lat) begin
               bus_done_i  = 1'b1;
               bus_rdata_i = bus_code_o ? code_word(bus_addr_o) : opr_resp(bus_addr_o);
               lg_code[n_tx % 256] = bus_code_o;
               lg_byte[n_tx % 256] = bus_byte_o;
               lg_we  [n_tx % 256] = bus_we_o;
               lg_addr[n_tx % 256] = bus_addr_o;
               lg_wd  [n_tx % 256] = bus_wdata_o;
               n_tx++;
               cnt = 0;
            end
         end
      end
   end

   task automatic rd_byte(output logic [7:0] v);
      while (!rd_valid_o) @(negedge clk);
      v = rd_data_o;
      rd_req_i = 1'b1;
      @(negedge clk);
      rd_req_i = 1'b0;
   endtask

   // flush to a new target, then poke the empty queue (R4, R6)
   task automatic do_branch(input logic [15:0] s, input logic [15:0] o);
      cs_i     = s;
      br_ip_i  = o;
      branch_i = 1'b1;
      @(negedge clk);
      branch_i = 1'b0;
      chk(rd_valid_o == 1'b0, "R6 queue empty after branch", rd_valid_o, 0);
      rd_req_i = 1'b1;
      @(negedge clk);
      rd_req_i = 1'b0;
   endtask

   task automatic opr_cycle(input logic we, input logic [19:0] a, input logic [15:0] wd,
                            output logic [15:0] rd);
      opr_req_i   = 1'b1;
      opr_we_i    = we;
      opr_addr_i  = a;
      opr_wdata_i = wd;
      do @(negedge clk); while (!opr_done_o);
      rd = opr_rdata_o;
      opr_req_i = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [15:0] cs_l [3];
      logic [15:0] ip_l [4];
      cs_l = '{16'h0000, 16'h1234, 16'hFFFF};
      ip_l = '{16'h0000, 16'h0006, 16'h0011, 16'hFFFD};
      rst_n = 1'b0; cs_i = '0; branch_i = 1'b0; br_ip_i = '0; rd_req_i = 1'b0;
      opr_req_i = 1'b0; opr_we_i = 1'b0; opr_addr_i = '0; opr_wdata_i = '0;
      repeat (3) @(negedge clk);
      chk(rd_valid_o == 1'b0, "R4 reset valid low", rd_valid_o, 0);
      chk(bus_req_o == 1'b0, "R11 reset bus idle", bus_req_o, 0);
      rst_n = 1'b1;

      // sweep segments, targets and latencies
      for (int ci = 0; ci < 3; ci++) begin
         for (int ii = 0; ii < 4; ii++) begin
            logic [15:0] s, o, o2;
            s = cs_l[ci];
            o = ip_l[ii];
            lat = 1 + ((ci + ii) % 4);
            repeat (60) @(negedge clk);
            n0 = n_tx;
            do_branch(s, o);
            repeat (40) @(negedge clk);
            chk(n_tx - n0 == 3, "R1 fetch count to fill", n_tx - n0, 3);
            chk(bus_req_o == 1'b0, "R11 idle when full", bus_req_o, 0);
            chk(lg_code[n0 % 256] && lg_addr[n0 % 256] == phys(s, o),
                "R7 first fetch address", lg_addr[n0 % 256], phys(s, o));
            chk(lg_byte[n0 % 256] == o[0], "R9 single byte on odd target",
                lg_byte[n0 % 256], o[0]);
            o2 = o + (o[0] ? 16'd1 : 16'd2);
            chk(lg_addr[(n0 + 1) % 256] == phys(s, o2), "R8 pointer advance",
                lg_addr[(n0 + 1) % 256], phys(s, o2));
            chk(!lg_byte[(n0 + 1) % 256] && !lg_addr[(n0 + 1) % 256][0],
                "R3 word fetch aligned", lg_addr[(n0 + 1) % 256], phys(s, o2));
            for (int k = 0; k < 20; k++) begin
               rd_byte(d);
               chk(d == cb(phys(s, o + 16'(k))), "R3 byte order", d, cb(phys(s, o + 16'(k))));
               if (k % 3 == 2) @(negedge clk);
            end
         end
      end

      // R11 / R2: no fetch with one free slot, fetch with two
      lat = 2;
      repeat (40) @(negedge clk);
      do_branch(16'h0ABC, 16'h0100);
      repeat (40) @(negedge clk);
      n0 = n_tx;
      rd_byte(d);
      chk(d == cb(phys(16'h0ABC, 16'h0100)), "R4 first byte", d, cb(phys(16'h0ABC, 16'h0100)));
      repeat (20) @(negedge clk);
      chk(n_tx == n0, "R11 no fetch at level five", n_tx - n0, 0);
      rd_byte(d);
      repeat (20) @(negedge clk);
      chk(n_tx == n0 + 1, "R2 fetch at level four", n_tx - n0, 1);
      for (int k = 2; k < 8; k++) begin
         rd_byte(d);
         chk(d == cb(phys(16'h0ABC, 16'h0100 + 16'(k))), "R4 stream after refill",
             d, cb(phys(16'h0ABC, 16'h0100 + 16'(k))));
      end

      // R10: branch while a slow fetch is in flight
      lat = 8;
      repeat (50) @(negedge clk);
      do_branch(16'h2000, 16'h0040);
      repeat (50) @(negedge clk);
      rd_byte(d);
      rd_byte(d);
      repeat (3) @(negedge clk);
      chk(bus_req_o && bus_code_o, "R10 fetch in flight", bus_req_o, 1);
      do_branch(16'h3000, 16'h0200);
      for (int k = 0; k < 8; k++) begin
         rd_byte(d);
         chk(d == cb(phys(16'h3000, 16'h0200 + 16'(k))), "R10 stale data dropped",
             d, cb(phys(16'h3000, 16'h0200 + 16'(k))));
      end

      // R5: operand raised during a code fetch waits for it
      lat = 6;
      repeat (50) @(negedge clk);
      n0 = n_tx;
      rd_byte(d);
      rd_byte(d);
      repeat (2) @(negedge clk);
      opr_cycle(1'b0, 20'h51234, 16'h0000, got_rd);
      chk(lg_code[n0 % 256] == 1'b1, "R5 fetch completes first", lg_code[n0 % 256], 1);
      chk(lg_code[(n0 + 1) % 256] == 1'b0, "R5 operand follows", lg_code[(n0 + 1) % 256], 0);
      chk(got_rd == opr_resp(20'h51234), "R12 operand read data", got_rd, opr_resp(20'h51234));

      // R2 / R12: operand wins over a fetch on an idle bus
      lat = 3;
      repeat (40) @(negedge clk);
      n0 = n_tx;
      cs_i = 16'h4444; br_ip_i = 16'h0010; branch_i = 1'b1;
      opr_req_i = 1'b1; opr_we_i = 1'b1; opr_addr_i = 20'hABCDE; opr_wdata_i = 16'h600D;
      @(negedge clk);
      branch_i = 1'b0;
      while (!opr_done_o) @(negedge clk);
      opr_req_i = 1'b0; opr_we_i = 1'b0;
      chk(lg_code[n0 % 256] == 1'b0, "R2 operand before fetch", lg_code[n0 % 256], 0);
      chk(lg_we[n0 % 256] && lg_addr[n0 % 256] == 20'hABCDE, "R12 write address",
          lg_addr[n0 % 256], 20'hABCDE);
      chk(lg_wd[n0 % 256] == 16'h600D, "R12 write data", lg_wd[n0 % 256], 16'h600D);
      for (int k = 0; k < 4; k++) begin
         rd_byte(d);
         chk(d == cb(phys(16'h4444, 16'h0010 + 16'(k))), "R6 resume at target",
             d, cb(phys(16'h4444, 16'h0010 + 16'(k))));
      end

      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule